// File: doc/BRIEF.md
# Crystal Clock Failure Monitor with RC Switchover

This block watches an external crystal clock from the free-running internal RC reference clock. The crystal clock drives a toggle flop. A synchroniser carries the toggle level into the reference domain, and every change of that level counts as one observed crystal edge. A counter then measures how many reference cycles pass with no observed edge. When that count reaches a programmable limit, the crystal counts as stuck at a constant level, which may be high or low. The block then raises a sticky failure flag and forces the system clock selection over to the RC oscillator.

The fallback stays locked until a reset or until software pulses the flag-clear strobe. A clear also restarts the quiet count, so a crystal that is still dead trips the monitor again one full timeout later. While the monitor is enabled, the RC oscillator enable output is held high whatever the software enable says, so the fallback clock is always running. The glitch-free clock multiplexer and the oscillators are not part of this block. The block only produces the selection and enable signals that feed them.

Top module: `xtal_fail_mon`

## Requirements
- R1: `rc_osc_en` is high whenever `mon_en` is high, and otherwise it follows `rc_en_sw`. It is combinational, with no cycle of delay.
- R2: While `mon_en` is low, the quiet counter is held at zero and `fail_flag` cannot become set, even if the crystal is stuck for any length of time.
- R3: Each rising edge of `xtal_clk` flips a toggle that passes through two reference-domain synchroniser flops. A change at the synchroniser output restarts the quiet count, so a running crystal whose rising edges come closer together than the timeout never trips the monitor.
- R4: The quiet count rises by one per reference cycle while the monitor is enabled and no edge is seen, and it saturates at its all-ones value. `fail_flag` is registered high on the reference edge at which the count, read before that edge, is at least the effective timeout.
- R5: A crystal held constantly high and a crystal held constantly low are both detected as failures.
- R6: `fail_flag` is sticky, and `failover` always equals it. A one-cycle `flag_clr` drops both on the next reference edge and resets the quiet count. If a clear and a detection fall in the same cycle, the clear wins.
- R7: `sel_xtal` equals `sel_xtal_sw` while `failover` is low, and it is forced low (RC selected) while `failover` is high.
- R8: A `tmo_cycles` value of 0 is treated as a timeout of 1.
- R9: Driving `rst_n` low clears the flag, the failover, the toggle, the synchroniser and the counter at once. The reference-domain logic leaves reset on the second reference edge after `rst_n` rises and starts working on the third.
- R10: Lowering `mon_en` after a failure does not clear `fail_flag` or `failover`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running internal RC reference clock |
| xtal_clk | input | 1 | Monitored crystal clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| mon_en | input | 1 | Monitor enable |
| rc_en_sw | input | 1 | Software RC oscillator enable |
| sel_xtal_sw | input | 1 | Software request to run the system clock from the crystal |
| flag_clr | input | 1 | One-cycle clear strobe for the failure flag (reference domain) |
| tmo_cycles | input | CNT_W | Quiet-cycle timeout in reference cycles |
| rc_osc_en | output | 1 | RC oscillator enable, forced high while monitoring |
| sel_xtal | output | 1 | Effective clock selection, 1 = crystal, 0 = RC |
| failover | output | 1 | High while the RC fallback is locked in |
| fail_flag | output | 1 | Sticky failure interrupt flag |

## Verification
The bench stops the crystal at a high level and at a low level, and it restarts it. A design that sensed only one polarity, or that reacted to level instead of toggles, would miss one of the stuck cases, or it would trip while the clock was running. The bench also clears the flag while the crystal is still dead, drops `mon_en` with the flag set, and programs a timeout of zero. A design that failed to restart the count on clear would trip again at once, and one whose clear lost to a same-cycle detection would show the same fault. A design that cleared on disable, or that counted past zero while disabled, would lose the flag or raise it when it should not. A reset applied in the middle of a failure checks that the flag drops asynchronously and that the three-cycle start-up delay is kept.

// File: rtl/xfm_pkg.sv
package xfm_pkg;

  // Failover latch state
  typedef enum logic {
    MON_WATCH   = 1'b0,
    MON_TRIPPED = 1'b1
  } fail_state_e;

  localparam int unsigned XFM_SYNC_STAGES = 2;
  localparam int unsigned XFM_RST_STAGES  = 2;

endpackage

// File: rtl/xfm_rst_sync.sv
module xfm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = 1'b1;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/xfm_edge_sync.sv
module xfm_edge_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic mon_clk,
  input  logic mon_rst_n,
  input  logic ref_clk,
  input  logic ref_rst_n,
  output logic edge_seen
);
  // Toggle flop in the monitored domain
  logic tog_q, tog_d;

  always_comb tog_d = ~tog_q;

  always_ff @(posedge mon_clk or negedge mon_rst_n) begin
    if (!mon_rst_n) tog_q <= 1'b0;
    else            tog_q <= tog_d;
  end

  // Synchroniser chain plus history flop in the reference domain
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q, prev_d;

  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_comb sync_d = tog_q;
    end else begin : g_sync_many
      always_comb sync_d = {sync_q[SYNC_STAGES-2:0], tog_q};
    end
  endgenerate

  always_comb prev_d = sync_q[SYNC_STAGES-1];

  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign edge_seen = sync_q[SYNC_STAGES-1] ^ prev_q;
endmodule

// File: rtl/xfm_quiet_timer.sv
module xfm_quiet_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             edge_seen,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] limit_eff;
  logic             cnt_clear;
  logic             cnt_ce;

  always_comb begin
    limit_eff = (limit == '0) ? CNT_ONE : limit;
    cnt_clear = !enable || edge_seen || restart;
    cnt_ce    = cnt_clear || (cnt_q != CNT_MAX);
    if (cnt_clear) cnt_d = '0;
    else           cnt_d = cnt_q + CNT_ONE;
    expired   = enable && (cnt_q >= limit_eff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/xfm_fail_latch.sv
module xfm_fail_latch
  import xfm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic trip,
  input  logic clr,
  output logic tripped
);
  fail_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (clr)       st_d = MON_WATCH;
    else if (trip) st_d = MON_TRIPPED;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= MON_WATCH;
    else        st_q <= st_d;
  end

  assign tripped = (st_q == MON_TRIPPED);
endmodule

// File: rtl/xtal_fail_mon.sv
module xtal_fail_mon
  import xfm_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             ref_clk,
  input  logic             xtal_clk,
  input  logic             rst_n,
  input  logic             mon_en,
  input  logic             rc_en_sw,
  input  logic             sel_xtal_sw,
  input  logic             flag_clr,
  input  logic [CNT_W-1:0] tmo_cycles,
  output logic             rc_osc_en,
  output logic             sel_xtal,
  output logic             failover,
  output logic             fail_flag
);
  logic rst_ref_n;
  logic edge_seen;
  logic expired;
  logic tripped;

  xfm_rst_sync #(.STAGES(XFM_RST_STAGES)) u_rst (
    .clk     (ref_clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_ref_n)
  );

  xfm_edge_sync #(.SYNC_STAGES(XFM_SYNC_STAGES)) u_edge (
    .mon_clk   (xtal_clk),
    .mon_rst_n (rst_n),
    .ref_clk   (ref_clk),
    .ref_rst_n (rst_ref_n),
    .edge_seen (edge_seen)
  );

  xfm_quiet_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (ref_clk),
    .rst_n     (rst_ref_n),
    .enable    (mon_en),
    .edge_seen (edge_seen),
    .restart   (flag_clr),
    .limit     (tmo_cycles),
    .expired   (expired)
  );

  xfm_fail_latch u_latch (
    .clk     (ref_clk),
    .rst_n   (rst_ref_n),
    .trip    (expired),
    .clr     (flag_clr),
    .tripped (tripped)
  );

  always_comb begin
    rc_osc_en = rc_en_sw | mon_en;
    failover  = tripped;
    fail_flag = tripped;
    sel_xtal  = sel_xtal_sw & ~tripped;
  end
endmodule

// File: rtl/xfm_checker.sv
module xfm_checker (
  input logic clk,
  input logic rst_n,
  input logic mon_en,
  input logic rc_osc_en,
  input logic flag_clr,
  input logic fail_flag,
  input logic failover,
  input logic sel_xtal
);
  // R1: monitoring forces the RC oscillator on
  a_r1_rc_forced: assert property (@(posedge clk) disable iff (!rst_n)
    mon_en |-> rc_osc_en);

  // R2: no new failure while the monitor is disabled
  a_r2_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!mon_en && !fail_flag) |=> !fail_flag);

  // R6: flag is sticky without a clear
  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_flag && !flag_clr) |=> fail_flag);

  // R6: clear wins and drops the flag on the next edge
  a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |=> !fail_flag);

  // R6: failover tracks the flag
  a_r6_failover_match: assert property (@(posedge clk) disable iff (!rst_n)
    failover == fail_flag);

  // R7: crystal never selected while failed over
  a_r7_sel_forced: assert property (@(posedge clk) disable iff (!rst_n)
    failover |-> !sel_xtal);
endmodule

bind xtal_fail_mon xfm_checker u_chk (
  .clk       (ref_clk),
  .rst_n     (rst_ref_n),
  .mon_en    (mon_en),
  .rc_osc_en (rc_osc_en),
  .flag_clr  (flag_clr),
  .fail_flag (fail_flag),
  .failover  (failover),
  .sel_xtal  (sel_xtal)
);

// File: tb/xtal_fail_mon_test.sv
module xtal_fail_mon_test;
  localparam int PERIOD = 10;
  localparam int CW     = 8;

  logic          ref_clk = 1'b0;
  logic          xtal_clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mon_en = 1'b0;
  logic          rc_en_sw = 1'b0;
  logic          sel_xtal_sw = 1'b0;
  logic          flag_clr = 1'b0;
  logic [CW-1:0] tmo_cycles = 8'd16;
  logic          rc_osc_en, sel_xtal, failover, fail_flag;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  // crystal stimulus control
  bit x_run = 0;
  int x_half = 2;
  int x_div = 0;
  int x_rise = 0;

  // reference model state
  int quiet = 0;
  int ecnt = 0;
  bit mflag = 0;
  bit hq[$] = '{0, 0, 0};

  xtal_fail_mon #(.CNT_W(CW)) uut (
    .ref_clk(ref_clk), .xtal_clk(xtal_clk), .rst_n(rst_n), .mon_en(mon_en),
    .rc_en_sw(rc_en_sw), .sel_xtal_sw(sel_xtal_sw), .flag_clr(flag_clr),
    .tmo_cycles(tmo_cycles), .rc_osc_en(rc_osc_en), .sel_xtal(sel_xtal),
    .failover(failover), .fail_flag(fail_flag)
  );

  always #(PERIOD/2) ref_clk = ~ref_clk;

  // crystal generator, changes only on reference falling edges
  always @(negedge ref_clk) begin
    if (!rst_n) x_rise = 0;
    if (x_run) begin
      x_div++;
      if (x_div >= x_half) begin
        x_div = 0;
        xtal_clk = ~xtal_clk;
        if (xtal_clk && rst_n) x_rise++;
      end
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit e;
    int te;
    bit hit;
    if (!rst_n) begin
      ecnt = 0; quiet = 0; mflag = 0; hq = '{0, 0, 0};
    end else if (ecnt < 2) begin
      ecnt++;
    end else begin
      e   = hq[1] ^ hq[2];
      te  = (tmo_cycles == 0) ? 1 : int'(tmo_cycles);
      hit = mon_en && (quiet >= te);
      if (flag_clr) mflag = 0;
      else if (hit) mflag = 1;
      if (!mon_en || e || flag_clr) quiet = 0;
      else if (quiet < 255) quiet++;
      void'(hq.pop_back());
      hq.push_front(x_rise[0]);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge ref_clk) begin
    model_step();
    #2;
    if (!done) begin
      chk("R4 fail_flag", fail_flag, mflag);
      chk("R6 failover", failover, mflag);
      chk("R7 sel_xtal", sel_xtal, sel_xtal_sw & ~mflag);
      chk("R1 rc_osc_en", rc_osc_en, rc_en_sw | mon_en);
    end
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge ref_clk);
  endtask

  task automatic pulse_clr();
    flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
  endtask

  initial begin : watchdog
    #(PERIOD * 150000);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin : stim
    cyc(2);
    // R9 reset state
    chk("R9 reset flag", fail_flag, 1'b0);
    chk("R9 reset failover", failover, 1'b0);
    rst_n = 1'b1;
    cyc(4);
    // R1 forcing
    rc_en_sw = 1'b0; mon_en = 1'b0; cyc(1);
    chk("R1 rc off", rc_osc_en, 1'b0);
    mon_en = 1'b1; cyc(1);
    chk("R1 forced on", rc_osc_en, 1'b1);
    // R3 running crystal never trips
    sel_xtal_sw = 1'b1; x_half = 2; x_run = 1; cyc(100);
    chk("R3 running no trip", fail_flag, 1'b0);
    chk("R7 crystal selected", sel_xtal, 1'b1);
    // R5 stuck high
    wait (xtal_clk == 1'b1); @(negedge ref_clk); x_run = 0;
    cyc(30);
    chk("R5 stuck high trips", fail_flag, 1'b1);
    chk("R7 forced to RC", sel_xtal, 1'b0);
    // R10 disable keeps flag
    mon_en = 1'b0; cyc(10);
    chk("R10 flag kept", fail_flag, 1'b1);
    // R2 disabled no detection
    pulse_clr(); cyc(60);
    chk("R2 disabled no trip", fail_flag, 1'b0);
    // R6 clear while still stuck, trips again later
    mon_en = 1'b1; cyc(25);
    chk("R6 retrip", fail_flag, 1'b1);
    pulse_clr();
    chk("R6 clear drops", fail_flag, 1'b0);
    cyc(10);
    chk("R6 count restarted", fail_flag, 1'b0);
    cyc(15);
    chk("R6 trips after full timeout", fail_flag, 1'b1);
    // clear and detection together
    tmo_cycles = 8'd3;
    pulse_clr(); cyc(2); pulse_clr();
    // R5 stuck low
    tmo_cycles = 8'd16; x_half = 1; x_run = 1; pulse_clr(); cyc(40);
    chk("R3 fast crystal no trip", fail_flag, 1'b0);
    wait (xtal_clk == 1'b0); @(negedge ref_clk); x_run = 0;
    cyc(30);
    chk("R5 stuck low trips", fail_flag, 1'b1);
    // R8 zero timeout
    tmo_cycles = 8'd0; x_half = 3; x_run = 1; pulse_clr(); cyc(20);
    x_run = 0; cyc(8);
    chk("R8 zero timeout trips", fail_flag, 1'b1);
    // R9 reset in the middle of failover
    @(posedge ref_clk); #7; rst_n = 1'b0; #1;
    chk("R9 async clear", fail_flag, 1'b0);
    chk("R9 async failover", failover, 1'b0);
    cyc(3); rst_n = 1'b1; tmo_cycles = 8'd5; cyc(2);
    chk("R9 held during sync", fail_flag, 1'b0);
    cyc(20);
    chk("R9 works after reset", fail_flag, 1'b1);
    cyc(3);
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule